// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This block computes the architectural state update that a processor core applies when it takes a trap. The core presents one trap per cycle on a strobe. Each trap carries a raw cause code, an interrupt flag, an optional translation-failure indication, the faulting address, the current program counter and privilege level, the two delegation masks, the two trap-vector bases and the interrupt-enable bits of both levels.

From these inputs the unit resolves the final cause. Environment calls are rewritten by privilege. Translation failures become page faults or access faults. The unit then decides whether the trap is handled at supervisor or machine level, and produces the new program counter and new privilege level. It also produces the values and write enables for the target level's cause, exception PC and trap-value registers and for its status fields. The whole update is computed combinationally and registered on the clock edge after the strobe, where the register file and fetch unit pick it up.

Top module: `trap_entry_unit`

## Requirements
- R1: The update appears on the outputs exactly one cycle after `trap_valid` is high, with `upd_valid` high for that one cycle. A cycle without the strobe yields `upd_valid`, `s_csr_we` and `m_csr_we` all low one cycle later. Consecutive strobes yield consecutive updates.
- R2: For an interrupt (`trap_irq`=1), the produced cause has bit XLEN-1 set and the raw code, zero-extended, in the low bits.
- R3: A non-interrupt trap with raw code 8 (environment call) is rewritten to 8 plus the current privilege encoding: U (0) gives 8, S (1) gives 9, level 2 gives 10 and M (3) gives 11.
- R4: Exceptions select the delegation bit from `exc_deleg` and interrupts select it from `irq_deleg`. The bit index is the resolved code, without the interrupt flag.
- R5: The trap targets supervisor level (`new_priv`=1, `s_csr_we`=1) only when `cur_priv` is 0 or 1 and the selected delegation bit is set. Otherwise it targets machine level (`new_priv`=3, `m_csr_we`=1). Exactly one of the two write enables is high with each update.
- R6: `new_pc` is the target level's vector base (`svec_base` or `mvec_base`), `epc_out` is `cur_pc`, and `cause_out` is the resolved cause.
- R7: `tval_out` equals `fault_addr` for non-interrupt codes 0, 1, 4, 5, 6, 7, 12, 13 and 15, and is zero for every other code and for every interrupt.
- R8: `new_pie` carries the old interrupt-enable bit of the target level (`st_sie` or `st_mie`), `new_pp` carries `cur_priv`, and `new_ie` is 0.
- R9: When `xlat_fault`=1 on an exception, the raw code is replaced according to the access kind `xlat_kind` (0 fetch, 1 load, 2 or 3 store). With `paging_on`=1 the codes are 12, 13 and 15. With `paging_on`=0 they are 1, 5 and 7.
- R10: While `rst` is high, and on the first cycle after reset is released, `upd_valid`, `s_csr_we` and `m_csr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trap_valid | input | 1 | A trap is taken this cycle |
| trap_irq | input | 1 | Trap is an interrupt |
| trap_code | input | CODE_W | Raw cause code |
| xlat_fault | input | 1 | Exception comes from an address-translation failure |
| xlat_kind | input | 2 | Access kind of the failed translation: 0 fetch, 1 load, 2/3 store |
| paging_on | input | 1 | Paged translation active (0 = bare) |
| fault_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege: 0 U, 1 S, 2 reserved level, 3 M |
| exc_deleg | input | XLEN | Exception delegation mask |
| irq_deleg | input | XLEN | Interrupt delegation mask |
| svec_base | input | XLEN | Supervisor trap vector base |
| mvec_base | input | XLEN | Machine trap vector base |
| st_sie | input | 1 | Current supervisor interrupt enable |
| st_mie | input | 1 | Current machine interrupt enable |
| upd_valid | output | 1 | Registered update is present |
| new_pc | output | XLEN | Next PC |
| new_priv | output | 2 | Next privilege level |
| s_csr_we | output | 1 | Write supervisor cause/EPC/trap value/status |
| m_csr_we | output | 1 | Write machine cause/EPC/trap value/status |
| cause_out | output | XLEN | Value for the target cause register |
| epc_out | output | XLEN | Value for the target EPC register |
| tval_out | output | XLEN | Value for the target trap-value register |
| new_pie | output | 1 | Value for the target previous-interrupt-enable field |
| new_pp | output | 2 | Value for the target previous-privilege field |
| new_ie | output | 1 | Value for the target interrupt-enable field |

## Verification
The bench builds the unit with its defaults, XLEN=32 and CODE_W=5. Every cause index 0 to 31 can then reach a delegation bit, and the interrupt flag lands on bit 31, where it can be told apart from the code. With a 5-bit code, the rewritten environment-call codes 9 and 11 and the page-fault codes 12 to 15 fit the field. Delegation masks with a bit set in one mask and clear in the other show which mask was used.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_AMO   = 2'd3
    } acc_e;

    localparam int C_FETCH_MIS  = 0;
    localparam int C_FETCH_ACC  = 1;
    localparam int C_LOAD_MIS   = 4;
    localparam int C_LOAD_ACC   = 5;
    localparam int C_STORE_MIS  = 6;
    localparam int C_STORE_ACC  = 7;
    localparam int C_ECALL_BASE = 8;
    localparam int C_FETCH_PF   = 12;
    localparam int C_LOAD_PF    = 13;
    localparam int C_STORE_PF   = 15;

    function automatic bit code_has_addr(input int code);
        case (code)
            C_FETCH_MIS, C_FETCH_ACC, C_LOAD_MIS, C_LOAD_ACC,
            C_STORE_MIS, C_STORE_ACC, C_FETCH_PF, C_LOAD_PF,
            C_STORE_PF: return 1'b1;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic int xlat_code(input acc_e kind, input logic paged);
        case (kind)
            ACC_FETCH: return paged ? C_FETCH_PF : C_FETCH_ACC;
            ACC_LOAD:  return paged ? C_LOAD_PF  : C_LOAD_ACC;
            default:   return paged ? C_STORE_PF : C_STORE_ACC;
        endcase
    endfunction

endpackage

// File: rtl/trap_cause_resolve.sv
module trap_cause_resolve
    import trap_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] raw_code,
    input  logic              xlat_fault,
    input  logic [1:0]        xlat_kind,
    input  logic              paging_on,
    input  logic [1:0]        priv,
    output logic [CODE_W-1:0] code,
    output logic [XLEN-1:0]   cause,
    output logic              has_addr
);
    localparam int LOW_W = (CODE_W < XLEN - 1) ? CODE_W : XLEN - 1;

    always_comb begin
        if (irq) begin
            code = raw_code;
        end else if (xlat_fault) begin
            code = CODE_W'(xlat_code(acc_e'(xlat_kind), paging_on));
        end else if (int'(raw_code) == C_ECALL_BASE) begin
            code = CODE_W'(C_ECALL_BASE + int'(priv));
        end else begin
            code = raw_code;
        end
    end

    always_comb begin
        cause = '0;
        cause[LOW_W-1:0] = code[LOW_W-1:0];
        cause[XLEN-1]    = irq;
    end

    assign has_addr = !irq && code_has_addr(int'(code));

endmodule

// File: rtl/trap_target_select.sv
module trap_target_select
    import trap_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              irq,
    input  logic [CODE_W-1:0] code,
    input  logic [1:0]        priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    output logic              to_super
);
    logic [XLEN-1:0] mask;
    logic            deleg_bit;
    logic            low_priv;

    assign mask     = irq ? irq_deleg : exc_deleg;
    assign low_priv = (priv == PRIV_U) || (priv == PRIV_S);

    always_comb begin
        deleg_bit = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            if (int'(code) == i) deleg_bit = mask[i];
        end
    end

    assign to_super = low_priv && deleg_bit;

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
    import trap_entry_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trap_valid,
    input  logic              trap_irq,
    input  logic [CODE_W-1:0] trap_code,
    input  logic              xlat_fault,
    input  logic [1:0]        xlat_kind,
    input  logic              paging_on,
    input  logic [XLEN-1:0]   fault_addr,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [1:0]        cur_priv,
    input  logic [XLEN-1:0]   exc_deleg,
    input  logic [XLEN-1:0]   irq_deleg,
    input  logic [XLEN-1:0]   svec_base,
    input  logic [XLEN-1:0]   mvec_base,
    input  logic              st_sie,
    input  logic              st_mie,
    output logic              upd_valid,
    output logic [XLEN-1:0]   new_pc,
    output logic [1:0]        new_priv,
    output logic              s_csr_we,
    output logic              m_csr_we,
    output logic [XLEN-1:0]   cause_out,
    output logic [XLEN-1:0]   epc_out,
    output logic [XLEN-1:0]   tval_out,
    output logic              new_pie,
    output logic [1:0]        new_pp,
    output logic              new_ie
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [1:0]      priv;
        logic            s_we;
        logic            m_we;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] epc;
        logic [XLEN-1:0] tval;
        logic            pie;
        logic [1:0]      pp;
    } trap_upd_t;

    logic [CODE_W-1:0] res_code;
    logic [XLEN-1:0]   res_cause;
    logic              res_has_addr;
    logic              to_super;
    trap_upd_t         nxt, cur;
    logic              vld_q;

    trap_cause_resolve #(.XLEN(XLEN), .CODE_W(CODE_W)) u_cause (
        .irq        (trap_irq),
        .raw_code   (trap_code),
        .xlat_fault (xlat_fault),
        .xlat_kind  (xlat_kind),
        .paging_on  (paging_on),
        .priv       (cur_priv),
        .code       (res_code),
        .cause      (res_cause),
        .has_addr   (res_has_addr)
    );

    trap_target_select #(.XLEN(XLEN), .CODE_W(CODE_W)) u_target (
        .irq       (trap_irq),
        .code      (res_code),
        .priv      (cur_priv),
        .exc_deleg (exc_deleg),
        .irq_deleg (irq_deleg),
        .to_super  (to_super)
    );

    always_comb begin
        nxt.pc    = to_super ? svec_base : mvec_base;
        nxt.priv  = to_super ? PRIV_S : PRIV_M;
        nxt.s_we  = trap_valid && to_super;
        nxt.m_we  = trap_valid && !to_super;
        nxt.cause = res_cause;
        nxt.epc   = cur_pc;
        nxt.tval  = res_has_addr ? fault_addr : '0;
        nxt.pie   = to_super ? st_sie : st_mie;
        nxt.pp    = cur_priv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
        end else begin
            vld_q <= trap_valid;
            if (trap_valid) begin
                cur <= nxt;
            end else begin
                cur.s_we <= 1'b0;
                cur.m_we <= 1'b0;
            end
        end
    end

    assign upd_valid = vld_q;
    assign new_pc    = cur.pc;
    assign new_priv  = cur.priv;
    assign s_csr_we  = cur.s_we;
    assign m_csr_we  = cur.m_we;
    assign cause_out = cur.cause;
    assign epc_out   = cur.epc;
    assign tval_out  = cur.tval;
    assign new_pie   = cur.pie;
    assign new_pp    = cur.pp;
    assign new_ie    = 1'b0;

    AST_STROBE_TO_UPDATE: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> upd_valid);  // R1
    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !trap_valid |=> !s_csr_we && !m_csr_we);  // R1
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        upd_valid |-> $onehot0({s_csr_we, m_csr_we}) && (s_csr_we || m_csr_we));  // R5
    AST_MACHINE_STAYS: assert property (@(posedge clk) disable iff (rst)
        trap_valid && cur_priv == 2'd3 |=> m_csr_we && new_priv == 2'd3);  // R5
    AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
        trap_valid && trap_irq |=> cause_out[XLEN-1]);  // R2
    AST_IRQ_NO_TVAL: assert property (@(posedge clk) disable iff (rst)
        trap_valid && trap_irq |=> tval_out == '0);  // R7
    AST_EPC_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> epc_out == $past(cur_pc));  // R6
    AST_PREV_PRIV: assert property (@(posedge clk) disable iff (rst)
        trap_valid |=> new_pp == $past(cur_priv));  // R8

endmodule

// File: tb/trap_entry_unit_test.sv
module trap_entry_unit_test;
    localparam int XLEN   = 32;
    localparam int CODE_W = 5;
    localparam logic [31:0] SVEC = 32'h8000_0100;
    localparam logic [31:0] MVEC = 32'h8000_0200;

    typedef struct packed {
        logic [31:0] pc;
        logic [1:0]  priv;
        logic        swe;
        logic        mwe;
        logic [31:0] cause;
        logic [31:0] epc;
        logic [31:0] tval;
        logic        pie;
        logic [1:0]  pp;
        logic        ie;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic trap_valid = 1'b0, trap_irq = 1'b0, xlat_fault = 1'b0, paging_on = 1'b0;
    logic [CODE_W-1:0] trap_code = '0;
    logic [1:0] xlat_kind = '0, cur_priv = '0;
    logic [31:0] fault_addr = '0, cur_pc = '0, exc_deleg = '0, irq_deleg = '0;
    logic st_sie = 1'b0, st_mie = 1'b0;
    logic upd_valid, s_csr_we, m_csr_we, new_pie, new_ie;
    logic [31:0] new_pc, cause_out, epc_out, tval_out;
    logic [1:0] new_priv, new_pp;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    trap_entry_unit #(.XLEN(XLEN), .CODE_W(CODE_W)) uut (
        .clk(clk), .rst(rst), .trap_valid(trap_valid), .trap_irq(trap_irq),
        .trap_code(trap_code), .xlat_fault(xlat_fault), .xlat_kind(xlat_kind),
        .paging_on(paging_on), .fault_addr(fault_addr), .cur_pc(cur_pc),
        .cur_priv(cur_priv), .exc_deleg(exc_deleg), .irq_deleg(irq_deleg),
        .svec_base(SVEC), .mvec_base(MVEC), .st_sie(st_sie), .st_mie(st_mie),
        .upd_valid(upd_valid), .new_pc(new_pc), .new_priv(new_priv),
        .s_csr_we(s_csr_we), .m_csr_we(m_csr_we), .cause_out(cause_out),
        .epc_out(epc_out), .tval_out(tval_out), .new_pie(new_pie),
        .new_pp(new_pp), .new_ie(new_ie)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic irq, input int code, input logic xf,
                                   input int kind, input logic pg, input logic [31:0] addr,
                                   input logic [31:0] pc, input int priv,
                                   input logic [31:0] ed, input logic [31:0] id,
                                   input logic sie, input logic mie);
        exp_t e;
        int   c = code;
        logic sup;
        if (!irq && xf) begin                                   // R9
            if (kind == 0)      c = pg ? 12 : 1;
            else if (kind == 1) c = pg ? 13 : 5;
            else                c = pg ? 15 : 7;
        end else if (!irq && code == 8) begin
            c = 8 + priv;                                       // R3
        end
        sup = (priv <= 1) && (irq ? id[c] : ed[c]);             // R4 R5
        e.pc    = sup ? SVEC : MVEC;                            // R6
        e.priv  = sup ? 2'd1 : 2'd3;
        e.swe   = sup;
        e.mwe   = !sup;
        e.cause = {irq, 31'(c)};                                // R2
        e.epc   = pc;
        e.tval  = (!irq && (c inside {0, 1, 4, 5, 6, 7, 12, 13, 15})) ? addr : 32'h0; // R7
        e.pie   = sup ? sie : mie;                              // R8
        e.pp    = 2'(priv);
        e.ie    = 1'b0;
        return e;
    endfunction

    task automatic fire(input string tag, input logic irq, input int code, input logic xf,
                        input int kind, input logic pg, input logic [31:0] addr,
                        input logic [31:0] pc, input int priv, input logic [31:0] ed,
                        input logic [31:0] id, input logic sie, input logic mie);
        @(negedge clk);
        trap_valid = 1'b1; trap_irq = irq; trap_code = CODE_W'(code); xlat_fault = xf;
        xlat_kind = 2'(kind); paging_on = pg; fault_addr = addr; cur_pc = pc;
        cur_priv = 2'(priv); exc_deleg = ed; irq_deleg = id; st_sie = sie; st_mie = mie;
        exp_q.push_back(model(irq, code, xf, kind, pg, addr, pc, priv, ed, id, sie, mie));
        tag_q.push_back(tag);
    endtask

    task automatic idle_check(input string tag);
        @(negedge clk);
        trap_valid = 1'b0;
        trap_code  = 5'd8;
        @(negedge clk);
        @(negedge clk);
        checks++;
        if (upd_valid || s_csr_we || m_csr_we) begin
            fails++;
            $display("FAIL %s idle: valid/swe/mwe=%b%b%b expected 000", tag,
                     upd_valid, s_csr_we, m_csr_we);
        end
    endtask

    // Monitor: pops expected items as updates appear.
    always @(negedge clk) begin
        if (!rst && upd_valid) begin
            exp_t  act, e;
            string t;
            act = {new_pc, new_priv, s_csr_we, m_csr_we, cause_out, epc_out,
                   tval_out, new_pie, new_pp, new_ie};
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R1 unexpected update: actual %h expected none", act);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (act !== e) begin
                    fails++;
                    $display("FAIL %s: actual %h expected %h", t, act, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (upd_valid || s_csr_we || m_csr_we) begin   // R10
            fails++;
            $display("FAIL R10 in reset: actual %b%b%b expected 000", upd_valid, s_csr_we, m_csr_we);
        end
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (upd_valid || s_csr_we || m_csr_we) begin   // R10
            fails++;
            $display("FAIL R10 after release: actual %b%b%b expected 000", upd_valid, s_csr_we, m_csr_we);
        end

        // R5 R7: illegal instruction from U, delegated
        fire("R5 deleg exc", 0, 2, 0, 0, 0, 32'hdead_0000, 32'h0000_1000, 0, 32'h0000_0004, 0, 1, 0);
        // R7: load page fault from S, not delegated, carries address
        fire("R7 load pf", 0, 13, 0, 0, 0, 32'h1234_5678, 32'h0000_1004, 1, 32'h0, 0, 0, 1);
        // R3: environment calls from each level
        fire("R3 ecall U", 0, 8, 0, 0, 0, 32'h5555_5555, 32'h0000_1008, 0, 32'h0000_0100, 0, 0, 0);
        fire("R3 ecall S", 0, 8, 0, 0, 0, 32'h0, 32'h0000_100c, 1, 32'h0000_0100, 0, 1, 1);
        fire("R3 ecall M", 0, 8, 0, 0, 0, 32'h0, 32'h0000_1010, 3, 32'hffff_ffff, 0, 0, 1);
        idle_check("R1 gap");
        // R2 R4: interrupt 5 from S delegated via interrupt mask
        fire("R2 irq deleg", 1, 5, 0, 0, 0, 32'hffff_0000, 32'h0000_2000, 1, 32'h0, 32'h0000_0020, 1, 0);
        // R5: same interrupt from M stays at M
        fire("R5 irq from M", 1, 5, 0, 0, 0, 32'h0, 32'h0000_2004, 3, 32'h0, 32'h0000_0020, 1, 1);
        // R4: exception 5 ignores interrupt mask bit 5
        fire("R4 mask sel", 0, 5, 0, 0, 0, 32'h0000_abcd, 32'h0000_2008, 0, 32'h0, 32'h0000_0020, 0, 1);
        // R4: interrupt 13 ignores exception mask bit 13
        fire("R4 irq mask", 1, 13, 0, 0, 0, 32'h0, 32'h0000_200c, 0, 32'h0000_2000, 32'h0, 1, 0);
        // R9: translation failures
        fire("R9 load paged", 0, 0, 1, 1, 1, 32'h7000_0010, 32'h0000_3000, 1, 32'h0000_2000, 0, 1, 0);
        fire("R9 fetch bare", 0, 0, 1, 0, 0, 32'h7000_0020, 32'h0000_3004, 0, 32'h0, 0, 0, 0);
        fire("R9 store paged", 0, 3, 1, 2, 1, 32'h7000_0030, 32'h0000_3008, 0, 32'h0000_8000, 0, 1, 1);
        fire("R9 amo bare", 0, 3, 1, 3, 0, 32'h7000_0040, 32'h0000_300c, 1, 32'h0000_0080, 0, 0, 1);
        // R7: store misaligned carries address; breakpoint (3) does not
        fire("R7 store mis", 0, 6, 0, 0, 0, 32'h0000_0003, 32'h0000_4000, 3, 32'h0, 0, 0, 0);
        fire("R7 no addr", 0, 3, 0, 0, 0, 32'h0bad_0bad, 32'h0000_4004, 0, 32'h0000_0008, 0, 1, 0);
        // R5: reserved level 2 is above S, never delegated
        fire("R5 level2", 0, 2, 0, 0, 0, 32'h0, 32'h0000_4008, 2, 32'hffff_ffff, 0, 1, 0);
        // R3: reserved-level environment call gives 10
        fire("R3 ecall L2", 0, 8, 0, 0, 0, 32'h0, 32'h0000_400c, 2, 32'h0, 0, 0, 1);
        // R8: supervisor entry with SIE=1, MIE=0 from U
        fire("R8 status", 0, 4, 0, 0, 0, 32'h0000_0011, 32'h0000_5000, 0, 32'h0000_0010, 0, 1, 0);
        idle_check("R1 tail");

        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R1 missing updates: actual %0d pending expected 0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule